// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits over a number of clock cycles and returns their full-width signed product of `2N` bits. A one-cycle `start` pulse, given while the block is idle, captures both operands. The block then runs exactly `N` iterations. In each iteration the lowest multiplier bit and the bit shifted out in the previous iteration pick one of three actions: add the multiplicand to the accumulator, add its stored negation, or leave the accumulator unchanged. An arithmetic right shift of the joined accumulator, multiplier and shifted-out bit follows.

The accumulator has one guard bit above `N`. With it, the negation of the most negative multiplicand, `-2^(N-1)`, is exact, so that operand gives the correct product like any other. When the last iteration finishes, `busy` falls and `done` pulses for one cycle. `product` then holds the result until the next accepted `start`.

Top module: `booth_mul`

## Requirements
- R1: While reset is asserted and after its release with no start, `busy` = 0, `done` = 0 and `product` = 0.
- R2: A `start` sampled high while `busy` is low sets `busy` in the next cycle, and `busy` then stays high for exactly `N` consecutive cycles.
- R3: `done` is high for exactly one cycle, the first cycle after `busy` falls, and at no other time.
- R4: When `done` is high, `product` equals the signed product of the captured `multiplicand` and `multiplier`, both read as `N`-bit two's complement, written as a `2N`-bit two's-complement value (for example +13 times +17 gives +221).
- R5: A `start` that arrives while `busy` is high is ignored: the running operation keeps its length and its result.
- R6: Once `done` has gone low, `product` holds its value until the next accepted `start`.
- R7: A multiplicand or a multiplier of `-2^(N-1)` gives the exact product, including `-2^(N-1)` times `-2^(N-1)` = `+2^(2N-2)`.
- R8: Changes on `multiplicand` and `multiplier` after the accepting cycle do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand, two's complement |
| multiplier | input | N | Signed multiplier, two's complement |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product becomes valid |
| product | output | 2N | Signed product, two's complement |

## Verification
The bench runs every operand pair of a 6-bit configuration, so both extreme values meet each other and every sign combination. A design with no guard bit on the accumulator returns a wrong sign or magnitude when the multiplicand is -32, and a logical shift in place of an arithmetic one corrupts every negative partial sum. Separate runs pulse `start` again in the middle of an operation and change the operand inputs while it is busy. A design that restarts, or that reads its operands again, then gives a different product or a wrong `busy` length. Each operation also checks that `done` lasts one cycle and that `product` stays frozen afterwards, which catches a counter that is off by one and an output that tracks the internal registers.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Action picked by the recoded bit pair of one iteration
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } booth_act_e;

  // Control state
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_st_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic       q_lsb,
  input  logic       q_prev,
  output booth_act_e act
);

  // Bit pair {current LSB, previously shifted-out bit}
  always_comb begin
    unique case ({q_lsb, q_prev})
      2'b10:   act = ACT_SUB;   // start of a run of ones
      2'b01:   act = ACT_ADD;   // end of a run of ones
      default: act = ACT_NONE;  // inside a run
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);

  localparam int SCW = $clog2(N + 1);

  booth_st_e        st_q, st_d;
  logic [SCW-1:0]   sc_q, sc_d;
  logic             done_q, done_d;
  logic             last;

  assign load = (st_q == ST_IDLE) && start;
  assign step = (st_q == ST_RUN);
  assign last = step && (sc_q == SCW'(1));

  always_comb begin
    st_d   = st_q;
    sc_d   = sc_q;
    done_d = 1'b0;
    if (load) begin
      st_d = ST_RUN;
      sc_d = SCW'(N);
    end else if (step) begin
      sc_d = sc_q - SCW'(1);
      if (last) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sc_q   <= sc_d;
      done_q <= done_d;
    end
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  input  booth_act_e     act,
  output logic           q_lsb,
  output logic           q_prev,
  output logic [2*N-1:0] product
);

  localparam int AW = N + 1;       // accumulator with guard bit
  localparam int SW = AW + N + 1;  // accumulator, multiplier, shifted-out bit

  logic [AW-1:0] acc_q,  acc_d;
  logic [N-1:0]  mq_q,   mq_d;
  logic          qx_q,   qx_d;
  logic [AW-1:0] bpos_q, bpos_d;
  logic [AW-1:0] bneg_q, bneg_d;

  logic [AW-1:0] m_ext;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;
  logic [SW-1:0] shifted;
  logic          en;

  assign m_ext = {mcand[N-1], mcand};
  assign en    = load | step;

  always_comb begin
    unique case (act)
      ACT_ADD: addend = bpos_q;
      ACT_SUB: addend = bneg_q;
      default: addend = '0;
    endcase
  end

  assign sum     = acc_q + addend;
  assign shifted = {sum[AW-1], sum, mq_q};

  always_comb begin
    acc_d  = acc_q;
    mq_d   = mq_q;
    qx_d   = qx_q;
    bpos_d = bpos_q;
    bneg_d = bneg_q;
    if (load) begin
      acc_d  = '0;
      mq_d   = mplier;
      qx_d   = 1'b0;
      bpos_d = m_ext;
      bneg_d = ~m_ext + AW'(1);
    end else if (step) begin
      acc_d = shifted[SW-1:N+1];
      mq_d  = shifted[N:1];
      qx_d  = shifted[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      mq_q   <= '0;
      qx_q   <= 1'b0;
      bpos_q <= '0;
      bneg_q <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      mq_q   <= mq_d;
      qx_q   <= qx_d;
      bpos_q <= bpos_d;
      bneg_q <= bneg_d;
    end
  end

  assign q_lsb   = mq_q[0];
  assign q_prev  = qx_q;
  assign product = {acc_q[N-1:0], mq_q};

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  logic       load, step;
  logic       q_lsb, q_prev;
  booth_act_e act;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  booth_recode u_recode (
    .q_lsb  (q_lsb),
    .q_prev (q_prev),
    .act    (act)
  );

  booth_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .mcand   (multiplicand),
    .mplier  (multiplier),
    .act     (act),
    .q_lsb   (q_lsb),
    .q_prev  (q_prev),
    .product (product)
  );

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [N-1:0]   multiplicand,
  input logic [N-1:0]   multiplier,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);

  localparam int SCW = $clog2(N + 1);

  logic [N-1:0]   cap_a, cap_b;
  logic [SCW-1:0] run_cnt;
  logic [2*N-1:0] ref_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_b   <= '0;
      run_cnt <= '0;
    end else if (start && !busy) begin
      cap_a   <= multiplicand;
      cap_b   <= multiplier;
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + SCW'(1);
    end
  end

  assign ref_prod = $signed({{N{cap_a[N-1]}}, cap_a}) * $signed({{N{cap_b[N-1]}}, cap_b});

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == SCW'(N)));

  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done == $fell(busy));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7 is covered by the same reference for extreme operands
  a_r4_product: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == ref_prod));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> $stable(product));

endmodule

bind booth_mul booth_mul_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .multiplicand (multiplicand),
  .multiplier   (multiplier),
  .busy         (busy),
  .done         (done),
  .product      (product)
);

// File: tb/booth_mul_tb.sv
module booth_mul_tb;

  localparam int N = 6;
  localparam int M = 1 << N;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [N-1:0]   mcand;
  logic [N-1:0]   mplier;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int n_chk;
  int n_bad;

  booth_mul #(.N(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .multiplicand (mcand),
    .multiplier   (mplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    int ai, bi;
    ai = $signed(a);
    bi = $signed(b);
    return (2*N)'(ai * bi);
  endfunction

  // Runs one operation; mode 1 pulses start mid-run (R5), mode 2 changes operands mid-run (R8)
  task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input int mode,
                        input bit full, input string req);
    int cnt;
    logic [2*N-1:0] held;
    @(negedge clk);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt   = 0;
    while (busy && cnt < 4*N) begin
      cnt++;
      if (cnt == 2 && mode == 1) begin
        start = 1'b1;
        mcand = ~a;
        mplier = b + 1'b1;
      end else if (cnt == 2 && mode == 2) begin
        mcand  = a + 1'b1;
        mplier = ~b;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(req, product, ref_mul(a, b));
    if (full) begin
      check("R2", cnt, N);
      check("R3", done, 1'b1);
      held = product;
      @(negedge clk);
      check("R3", done, 1'b0);
      check("R6", product, held);
      repeat (3) @(negedge clk);
      check("R6", product, held);
    end
  endtask

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    check("R1", {busy, done}, 2'b00);
    check("R1", product, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {busy, done}, 2'b00);
    check("R1", product, '0);

    // R4: 13 * 17
    run_op(N'(13), N'(17), 0, 1'b1, "R4");
    check("R4", product, (2*N)'(221));
    // R7: extreme operands
    run_op(N'(1) << (N-1), N'(1) << (N-1), 0, 1'b1, "R7");
    run_op(N'(1) << (N-1), N'(-1), 0, 1'b1, "R7");
    run_op(N'(-1), N'(1) << (N-1), 0, 1'b1, "R7");
    // R5: start during busy ignored
    run_op(N'(5), N'(-7), 1, 1'b1, "R5");
    run_op(N'(-19), N'(11), 1, 1'b1, "R5");
    // R8: operand changes during busy ignored
    run_op(N'(-3), N'(25), 2, 1'b1, "R8");
    run_op(N'(31), N'(-32), 2, 1'b1, "R8");

    // R4 and R7: exhaustive sweep
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) begin
        run_op(N'(i), N'(j), 0, ((i + j) % 97) == 0, "R4");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule